// File: doc/BRIEF.md
# One-Time-Programmable Byte Memory Mode Model

This block is a synthesizable behavioural model of a small one-time-programmable byte memory with a two-enable, EPROM-style control interface. It serves as a test target for read sequencers and programming controllers. The model keeps an array of bytes that come out of reset fully erased, with every bit at 1. Programming can only clear bits.

On every cycle the model decodes an operating mode from four inputs: the programming-voltage flag, chip enable, output enable and the identifier flag. It then drives the array byte, an identifier code or nothing. Chip enable is sampled on the system clock, and a write happens once for each sampled falling edge of chip enable in programming mode.

An optional weak cell can be placed at one bit of one address. That bit needs several program pulses before it clears, so a controller's retry loop can be exercised against it.

Top module: `otp_mode_model`

## Requirements
- R1: After reset every byte of the array reads 0xFF.
- R2: With the programming flag low, both enables low and the identifier flag low, `q_en` is 1 and `q` equals the stored byte at `addr`.
- R3: With the programming flag low and `ce_n` high (standby), `q_en` is 0 whatever `oe_n` is.
- R4: With the programming flag low, `ce_n` low and `oe_n` high (output disable), `q_en` is 0.
- R5: With the programming flag high and `oe_n` high, a falling edge of `ce_n` seen at a clock edge replaces the byte at `addr` with its old value bitwise-ANDed with `din`. The new value is readable from the cycle after that edge.
- R6: A single low period of `ce_n` writes once, however many clock cycles it lasts.
- R7: A stored bit never returns from 0 to 1, and a 1 in `din` leaves the stored bit unchanged.
- R8: With the programming flag high, `oe_n` low and `ce_n` high (verify), `q_en` is 1 and `q` equals the stored byte.
- R9: With the programming flag high and both enables high (inhibit), `q_en` is 0. A falling edge of `ce_n` while the programming flag is low writes nothing.
- R10: With the programming flag high and both enables low, `q_en` is 0 and a falling `ce_n` writes nothing.
- R11: With the programming flag low, the identifier flag high and both enables low, `q` is 0x20 when `addr[0]` is 0 and 0xB4 when `addr[0]` is 1, whatever the upper address bits are.
- R12: Bit WEAK_BIT of address WEAK_ADDR clears only on the WEAK_PULSES-th pulse that carries a 0 in that `din` bit. The other bits of that byte clear on the first such pulse.
- R13: `q` is 0 whenever `q_en` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; erases the array to all ones |
| addr | input | ADDR_W | Byte address; bit 0 also selects the identifier byte |
| ce_n | input | 1 | Chip enable, active low; a sampled falling edge is a program pulse |
| oe_n | input | 1 | Output enable, active low |
| vpp_on | input | 1 | Programming voltage present |
| sig_on | input | 1 | High voltage present on the identifier-select address line |
| din | input | DATA_W | Byte to be programmed |
| q | output | DATA_W | Read data; zero while not driven |
| q_en | output | 1 | Output driven; low stands for high impedance |

## Verification
The bench walks all eight combinations of the programming flag and the two enables, both with and without the identifier flag. Each combination has its own expected drive state, so this separates a wrong mode decode from a wrong data path.

Program patterns are layered on one address, for example 0xA5 followed by 0xF0. A pattern containing 1s shows whether the design ANDs the new data in or simply overwrites the byte.

A single long chip-enable pulse on the weak cell is followed by short ones. A write counted once per cycle would clear the weak bit early, while a write counted once per edge clears it exactly on the third pulse.

Chip-enable falls in read mode and in the both-enables-low programming case are each followed by a read-back. These read-backs catch a write strobe that does not qualify on mode.

// File: rtl/otp_pkg.sv
`timescale 1ns/1ps
package otp_pkg;

  typedef enum logic [2:0] {
    MD_STANDBY,
    MD_DISABLE,
    MD_READ,
    MD_IDENT,
    MD_PROGRAM,
    MD_VERIFY,
    MD_INHIBIT,
    MD_CLASH
  } otp_mode_e;

  localparam logic [7:0] IDENT_MAKER  = 8'h20;
  localparam logic [7:0] IDENT_DEVICE = 8'hB4;

  function automatic otp_mode_e decode_mode(input logic vpp, input logic sig,
                                            input logic ce_n, input logic oe_n);
    otp_mode_e m;
    if (vpp) begin
      case ({ce_n, oe_n})
        2'b01:   m = MD_PROGRAM;
        2'b10:   m = MD_VERIFY;
        2'b11:   m = MD_INHIBIT;
        default: m = MD_CLASH;
      endcase
    end else if (ce_n) begin
      m = MD_STANDBY;
    end else if (oe_n) begin
      m = MD_DISABLE;
    end else begin
      m = sig ? MD_IDENT : MD_READ;
    end
    return m;
  endfunction

  function automatic logic [7:0] ident_byte(input logic sel);
    return sel ? IDENT_DEVICE : IDENT_MAKER;
  endfunction

  // One-way write: only 1 -> 0 transitions are possible.
  function automatic logic [7:0] burn(input logic [7:0] old_v, input logic [7:0] pat);
    return old_v & pat;
  endfunction

endpackage

// File: rtl/otp_mode_dec.sv
`timescale 1ns/1ps
module otp_mode_dec
  import otp_pkg::*;
(
  input  logic      vpp_on,
  input  logic      sig_on,
  input  logic      ce_n,
  input  logic      oe_n,
  output otp_mode_e mode,
  output logic      drv_array,
  output logic      drv_ident,
  output logic      prog_sel
);
  always_comb begin
    mode      = decode_mode(vpp_on, sig_on, ce_n, oe_n);
    drv_array = (mode == MD_READ) || (mode == MD_VERIFY);
    drv_ident = (mode == MD_IDENT);
    prog_sel  = (mode == MD_PROGRAM);
  end
endmodule

// File: rtl/otp_fall_det.sv
`timescale 1ns/1ps
module otp_fall_det (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_n,
  output logic fall
);
  logic sig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sig_q <= 1'b1;
    else        sig_q <= sig_n;
  end

  assign fall = sig_q & ~sig_n;
endmodule

// File: rtl/otp_array.sv
`timescale 1ns/1ps
module otp_array
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int WEAK_ADDR   = 5,
  parameter int WEAK_BIT    = 2,
  parameter int WEAK_PULSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] cur;
  logic [DATA_W-1:0] nxt;
  logic              weak_hit;
  logic              weak_hold;

  assign cur      = mem[addr];
  assign rd_data  = cur;
  assign weak_hit = wr_en && (addr == ADDR_W'(WEAK_ADDR)) &&
                    cur[WEAK_BIT] && !din[WEAK_BIT];

  generate
    if (WEAK_PULSES > 1) begin : g_weak
      localparam int CNT_W = $clog2(WEAK_PULSES + 1);
      logic [CNT_W-1:0] hits;
      always_ff @(posedge clk) begin
        if (!rst_n)        hits <= '0;
        else if (weak_hit) hits <= hits + 1'b1;
      end
      assign weak_hold = weak_hit && ((int'(hits) + 1) < WEAK_PULSES);
    end else begin : g_plain
      assign weak_hold = 1'b0;
    end
  endgenerate

  always_comb begin
    nxt = DATA_W'(burn(8'(cur), 8'(din)));
    if (DATA_W > 8) nxt[DATA_W-1:0] = cur & din;
    if (weak_hold) nxt[WEAK_BIT] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
    end else if (wr_en) begin
      mem[addr] <= nxt;
    end
  end
endmodule

// File: rtl/otp_mode_model.sv
`timescale 1ns/1ps
module otp_mode_model
  import otp_pkg::*;
#(
  parameter int ADDR_W      = 6,
  parameter int DATA_W      = 8,
  parameter int WEAK_ADDR   = 5,
  parameter int WEAK_BIT    = 2,
  parameter int WEAK_PULSES = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              vpp_on,
  input  logic              sig_on,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              q_en
);
  otp_mode_e         mode;
  logic              drv_array;
  logic              drv_ident;
  logic              prog_sel;
  logic              ce_fall;
  logic              wr_fire;
  logic [DATA_W-1:0] arr_rd;

  otp_mode_dec u_dec (
    .vpp_on   (vpp_on),
    .sig_on   (sig_on),
    .ce_n     (ce_n),
    .oe_n     (oe_n),
    .mode     (mode),
    .drv_array(drv_array),
    .drv_ident(drv_ident),
    .prog_sel (prog_sel)
  );

  otp_fall_det u_fall (
    .clk  (clk),
    .rst_n(rst_n),
    .sig_n(ce_n),
    .fall (ce_fall)
  );

  assign wr_fire = ce_fall && prog_sel;

  otp_array #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .WEAK_ADDR  (WEAK_ADDR),
    .WEAK_BIT   (WEAK_BIT),
    .WEAK_PULSES(WEAK_PULSES)
  ) u_arr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_fire),
    .addr   (addr),
    .din    (din),
    .rd_data(arr_rd)
  );

  always_comb begin
    q    = '0;
    q_en = drv_array || drv_ident;
    if (drv_array)      q = arr_rd;
    else if (drv_ident) q = DATA_W'(ident_byte(addr[0]));
  end
endmodule

// File: rtl/otp_mode_chk.sv
`timescale 1ns/1ps
module otp_mode_chk #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              ce_n,
  input logic              oe_n,
  input logic              vpp_on,
  input logic              sig_on,
  input logic [DATA_W-1:0] q,
  input logic              q_en,
  input logic              wr_fire,
  input logic [DATA_W-1:0] arr_rd
);
  // R13
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !q_en |-> (q == '0));
  // R3
  standby_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && ce_n) |-> !q_en);
  // R4
  out_disable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && !ce_n && oe_n) |-> !q_en);
  // R9
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && ce_n && oe_n) |-> (!q_en && !wr_fire));
  // R10
  clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && !ce_n && !oe_n) |-> (!q_en && !wr_fire));
  // R8
  verify_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vpp_on && ce_n && !oe_n) |-> (q_en && q == arr_rd));
  // R11
  ident_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vpp_on && sig_on && !ce_n && !oe_n) |->
      (q_en && q == (addr[0] ? DATA_W'(8'hB4) : DATA_W'(8'h20))));
  // R6
  single_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> !wr_fire);
  // R7
  no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fire |=> (!$stable(addr) || ((arr_rd & ~$past(arr_rd)) == '0)));
endmodule

bind otp_mode_model otp_mode_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
  .vpp_on(vpp_on), .sig_on(sig_on), .q(q), .q_en(q_en),
  .wr_fire(wr_fire), .arr_rd(arr_rd)
);

// File: tb/tb_otp_mode_model.sv
`timescale 1ns/1ps
module tb_otp_mode_model;
  localparam int AW = 6;
  localparam int WA = 5;
  localparam int WB = 2;
  localparam int WP = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic          vpp_on = 1'b0;
  logic          sig_on = 1'b0;
  logic [7:0]    din = 8'hFF;
  logic [7:0]    q;
  logic          q_en;

  int  n_tests = 0;
  int  n_fail  = 0;
  bit  done    = 1'b0;

  always #2 clk = ~clk;

  otp_mode_model #(.ADDR_W(AW), .DATA_W(8), .WEAK_ADDR(WA), .WEAK_BIT(WB),
                   .WEAK_PULSES(WP)) dut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .ce_n(ce_n), .oe_n(oe_n),
    .vpp_on(vpp_on), .sig_on(sig_on), .din(din), .q(q), .q_en(q_en)
  );

  // Behavioural reference state
  logic [7:0] ref_mem [1<<AW];
  int         weak_cnt;
  logic       last_ce;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < (1<<AW); i++) ref_mem[i] = 8'hFF;
      weak_cnt = 0;
      last_ce  = 1'b1;
    end else begin
      if (last_ce && !ce_n && vpp_on && oe_n) begin
        logic [7:0] v;
        v = ref_mem[addr];
        for (int b = 0; b < 8; b++) begin
          if (!din[b] && v[b]) begin
            if (int'(addr) == WA && b == WB) begin
              weak_cnt++;
              if (weak_cnt >= WP) v[b] = 1'b0;
            end else begin
              v[b] = 1'b0;
            end
          end
        end
        ref_mem[addr] = v;
      end
      last_ce = ce_n;
    end
  end

  task automatic chk(input string req, input logic [7:0] av, input logic [7:0] ev,
                     input logic aen, input logic een);
    n_tests++;
    if (av !== ev || aen !== een) begin
      n_fail++;
      $display("FAIL %s: q=%02h q_en=%0b expected q=%02h q_en=%0b",
               req, av, aen, ev, een);
    end
  endtask

  // Per-cycle comparison against the reference
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      string      tag;
      logic       een;
      logic [7:0] ev;
      een = 1'b0; ev = 8'h00;
      if (vpp_on) begin
        if (ce_n && !oe_n)      begin tag = "R8";  een = 1'b1; ev = ref_mem[addr]; end
        else if (ce_n && oe_n)  tag = "R9";
        else if (oe_n)          tag = "R5";
        else                    tag = "R10";
      end else if (ce_n)        tag = "R3";
      else if (oe_n)            tag = "R4";
      else if (sig_on)          begin tag = "R11"; een = 1'b1; ev = addr[0] ? 8'hB4 : 8'h20; end
      else                      begin tag = "R2";  een = 1'b1; ev = ref_mem[addr]; end
      chk({tag, " (per-cycle, R13 idle zero)"}, q, ev, q_en, een);
    end
  end

  task automatic set_in(input logic v, input logic s, input logic c, input logic o,
                        input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    vpp_on = v; sig_on = s; ce_n = c; oe_n = o; addr = a; din = d;
  endtask

  task automatic rd_chk(input logic [AW-1:0] a, input logic [7:0] ev, input string req);
    set_in(1'b0, 1'b0, 1'b1, 1'b1, a, 8'hFF);
    set_in(1'b0, 1'b0, 1'b0, 1'b0, a, 8'hFF);
    #1 chk(req, q, ev, q_en, 1'b1);
  endtask

  task automatic burn_pulse(input logic [AW-1:0] a, input logic [7:0] d, input int low_cycles);
    set_in(1'b1, 1'b0, 1'b1, 1'b1, a, d);
    set_in(1'b1, 1'b0, 1'b0, 1'b1, a, d);
    repeat (low_cycles - 1) @(negedge clk);
    set_in(1'b1, 1'b0, 1'b1, 1'b1, a, d);
    set_in(1'b0, 1'b0, 1'b1, 1'b1, a, 8'hFF);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    #800000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;

    // R1: erased state
    rd_chk(6'd0,  8'hFF, "R1 erased addr 0");
    rd_chk(6'd63, 8'hFF, "R1 erased addr 63");

    // R3 standby with oe low, R4 output disable, R13 zero data
    set_in(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 8'hFF);
    #1 chk("R3 standby", q, 8'h00, q_en, 1'b0);
    set_in(1'b0, 1'b0, 1'b0, 1'b1, 6'd0, 8'hFF);
    #1 chk("R4 output disable", q, 8'h00, q_en, 1'b0);

    // R5 program, R2 read back
    burn_pulse(6'd3, 8'hA5, 1);
    rd_chk(6'd3, 8'hA5, "R5 programmed byte");
    rd_chk(6'd4, 8'hFF, "R2 neighbour untouched");

    // R7 ones in din keep bits, zeros never return to one
    burn_pulse(6'd3, 8'hF0, 1);
    rd_chk(6'd3, 8'hA0, "R7 AND merge");
    burn_pulse(6'd3, 8'hFF, 2);
    rd_chk(6'd3, 8'hA0, "R7 all-ones pattern");

    // R8 verify drives stored byte
    set_in(1'b1, 1'b0, 1'b1, 1'b0, 6'd3, 8'h00);
    #1 chk("R8 verify", q, 8'hA0, q_en, 1'b1);

    // R9 inhibit, then ce fall without programming voltage
    set_in(1'b1, 1'b0, 1'b1, 1'b1, 6'd8, 8'h00);
    #1 chk("R9 inhibit hi-z", q, 8'h00, q_en, 1'b0);
    set_in(1'b0, 1'b0, 1'b1, 1'b1, 6'd8, 8'h00);
    set_in(1'b0, 1'b0, 1'b0, 1'b1, 6'd8, 8'h00);
    set_in(1'b0, 1'b0, 1'b1, 1'b1, 6'd8, 8'h00);
    rd_chk(6'd8, 8'hFF, "R9 no write without programming voltage");

    // R10 programming voltage with both enables low
    set_in(1'b1, 1'b0, 1'b1, 1'b0, 6'd7, 8'h00);
    set_in(1'b1, 1'b0, 1'b0, 1'b0, 6'd7, 8'h00);
    #1 chk("R10 clash hi-z", q, 8'h00, q_en, 1'b0);
    set_in(1'b1, 1'b0, 1'b1, 1'b1, 6'd7, 8'h00);
    rd_chk(6'd7, 8'hFF, "R10 no write on clash");

    // R11 identifier bytes
    set_in(1'b0, 1'b1, 1'b0, 1'b0, 6'd0, 8'hFF);
    #1 chk("R11 maker code", q, 8'h20, q_en, 1'b1);
    set_in(1'b0, 1'b1, 1'b0, 1'b0, 6'd1, 8'hFF);
    #1 chk("R11 device code", q, 8'hB4, q_en, 1'b1);
    set_in(1'b0, 1'b1, 1'b0, 1'b0, 6'd62, 8'hFF);
    #1 chk("R11 upper bits ignored", q, 8'h20, q_en, 1'b1);

    // R6 long pulse counts once, R12 weak cell needs WP pulses
    burn_pulse(6'(WA), 8'h00, 5);
    rd_chk(6'(WA), 8'h04, "R12 weak bit survives first pulse");
    burn_pulse(6'(WA), 8'h00, 1);
    rd_chk(6'(WA), 8'h04, "R6 long pulse counted once");
    burn_pulse(6'(WA), 8'h00, 1);
    rd_chk(6'(WA), 8'h00, "R12 weak bit clears on third pulse");

    set_in(1'b0, 1'b0, 1'b1, 1'b1, 6'd0, 8'hFF);
    @(negedge clk);
    finish_run();
  end
endmodule